// File: doc/BRIEF.md
# Twelve-Step Hour Counter

This block is a fully synchronous 4-bit counter that runs through the values 1, 2, … 12 and then returns to 1, the way the hour field of a wall clock does. Every state bit sits on the same clock. Each bit is a toggle cell: on a counting edge it inverts when its own toggle condition, formed from the present state, is true, and it keeps its value otherwise. The return from 12 to 1 happens on one edge, like every other step.

A synchronous reset loads 1. A count enable gates every step; with the enable low the state holds. A combinational wrap output marks the cycle in which the next edge will carry the count from 12 back to 1, so a following stage can step on that edge. The four codes outside the sequence (0, 13, 14, 15) are not trapped: from any of them the toggle conditions lead back into 1..12 within two counting edges.

Top module: `hour12_counter`

## Requirements
- R1: With rst high at a rising clock edge, count becomes 1 after that edge, whatever the enable and the present count.
- R2: With cnt_en low and rst low at an edge, count keeps its value across that edge.
- R3: With cnt_en high, a count from 1 to 11 becomes the count plus one after the edge.
- R4: With cnt_en high, a count of 12 becomes 1 after one edge, and wrap is high during the cycle before that edge.
- R5: count[0] (bit A) inverts on every enabled edge; count[1] (bit B) inverts on an enabled edge exactly when count[0] was 1.
- R6: count[2] (bit C) inverts on an enabled edge exactly when (A and B) or (C and D) held; count[3] (bit D) inverts exactly when (A and B and C) or (C and D) held.
- R7: From the unused codes 13 and 14 an enabled edge leads to 2 and 3 respectively.
- R8: From the unused code 15 an enabled edge leads to 0, and from 0 an enabled edge leads to 1.
- R9: wrap is low whenever cnt_en is low or count differs from 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high, loads 1 |
| cnt_en | input | 1 | Count enable, active high |
| count | output | 4 | Present count; bit 0 is A, bit 3 is D |
| wrap | output | 1 | High while count is 12 and the enable is high |

## Verification
The count is registered, so a stimulus applied before a rising edge shows on count one edge later; the bench drives on the falling edge and reads the new count on the following falling edge. The wrap output is combinational from the present count and enable, so it is read in the same half-cycle in which the enable was driven, before the edge it announces. Unused codes are placed into the state register during a reset cycle, so each recovery step is again read one falling edge after the rising edge that produced it.

// File: rtl/hour12_pkg.sv
package hour12_pkg;

  localparam int CNT_W = 4;

  typedef logic [CNT_W-1:0] hour_t;

  localparam hour_t LAST_CODE  = 4'd12;
  localparam hour_t FIRST_CODE = 4'd1;

  // Toggle condition of each bit, from the present state.
  // Bit 0 is A (least significant), bit 3 is D.
  function automatic hour_t hour12_toggle_mask(input hour_t q);
    hour_t m;
    m[0] = 1'b1;
    m[1] = q[0];
    m[2] = (q[0] & q[1]) | (q[2] & q[3]);
    m[3] = (q[0] & q[1] & q[2]) | (q[2] & q[3]);
    return m;
  endfunction

  // Next state of a bank of toggle cells.
  function automatic hour_t hour12_apply(input hour_t q, input hour_t m, input logic en);
    hour_t n;
    for (int i = 0; i < CNT_W; i++) begin
      n[i] = (en & m[i]) ? ~q[i] : q[i];
    end
    return n;
  endfunction

endpackage

// File: rtl/hour12_toggle_logic.sv
module hour12_toggle_logic
  import hour12_pkg::*;
(
  input  hour_t state_i,
  output hour_t tog_o
);

  assign tog_o = hour12_toggle_mask(state_i);

endmodule

// File: rtl/hour12_state_bank.sv
module hour12_state_bank
  import hour12_pkg::*;
#(
  parameter hour_t RESET_CODE = FIRST_CODE
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  hour_t tog_i,
  output hour_t state_o
);

  hour_t state_q;
  hour_t state_d;

  // One toggle cell per bit.
  for (genvar i = 0; i < CNT_W; i++) begin : g_cell
    assign state_d[i] = (en & tog_i[i]) ? ~state_q[i] : state_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RESET_CODE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/hour12_wrap_detect.sv
module hour12_wrap_detect
  import hour12_pkg::*;
(
  input  hour_t state_i,
  input  logic  en,
  output logic  wrap_o
);

  assign wrap_o = en && (state_i == LAST_CODE);

endmodule

// File: rtl/hour12_counter.sv
module hour12_counter
  import hour12_pkg::*;
#(
  parameter hour_t RESET_CODE = FIRST_CODE
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cnt_en,
  output logic [3:0] count,
  output logic       wrap
);

  hour_t state_w;
  hour_t tog_w;
  logic  wrap_w;

  hour12_toggle_logic u_tog (
    .state_i (state_w),
    .tog_o   (tog_w)
  );

  hour12_state_bank #(
    .RESET_CODE (RESET_CODE)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .en      (cnt_en),
    .tog_i   (tog_w),
    .state_o (state_w)
  );

  hour12_wrap_detect u_wrap (
    .state_i (state_w),
    .en      (cnt_en),
    .wrap_o  (wrap_w)
  );

  assign count = state_w;
  assign wrap  = wrap_w;

endmodule

// File: rtl/hour12_counter_chk.sv
module hour12_counter_chk (
  input logic       clk,
  input logic       rst,
  input logic       cnt_en,
  input logic [3:0] count,
  input logic       wrap,
  input logic [3:0] tog
);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(count));

  // R3
  step_plus_one_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count >= 4'd1 && count <= 4'd11) |=> (count == $past(count) + 4'd1));

  // R4
  wrap_returns_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (count == 4'd1));

  // R5
  bit_a_flips_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> (count[0] != $past(count[0])));

  // R5
  bit_b_rule_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> (count[1] == ($past(count[1]) ^ $past(count[0]))));

  // R6
  toggle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> (count == ($past(count) ^ $past(tog))));

  // R7
  recover_13_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count == 4'd13) |=> (count == 4'd2));

  // R7
  recover_14_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count == 4'd14) |=> (count == 4'd3));

  // R8
  recover_15_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count == 4'd15) |=> (count == 4'd0));

  // R8
  recover_0_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count == 4'd0) |=> (count == 4'd1));

  // R9
  wrap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en || count != 4'd12) |-> !wrap);

endmodule

bind hour12_counter hour12_counter_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .cnt_en (cnt_en),
  .count  (count),
  .wrap   (wrap),
  .tog    (tog_w)
);

// File: tb/test_hour12_counter.sv
module test_hour12_counter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic [3:0] count;
  logic       wrap;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  hour12_counter i_hour12_counter (
    .clk    (clk),
    .rst    (rst),
    .cnt_en (cnt_en),
    .count  (count),
    .wrap   (wrap)
  );

  always #2 clk = ~clk;

  // Reference successor on an enabled edge, written as the sequence table.
  function automatic logic [3:0] ref_next(input logic [3:0] c);
    case (c)
      4'd12:   return 4'd1;
      4'd13:   return 4'd2;
      4'd14:   return 4'd3;
      4'd15:   return 4'd0;
      4'd0:    return 4'd1;
      default: return c + 4'd1;
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One enabled edge from a known value, with wrap and bit-rule checks.
  task automatic step_on(inout logic [3:0] cur);
    logic [3:0] nxt;
    logic [3:0] flip;
    cnt_en = 1'b1;
    #0;
    check(cur == 4'd12 ? "R4 wrap before edge" : "R9 wrap quiet", {3'b0, wrap}, {3'b0, cur == 4'd12});
    @(negedge clk);
    nxt = ref_next(cur);
    check(cur == 4'd12 ? "R4" : (cur >= 4'd13 ? "R7" : ((cur == 4'd15 || cur == 4'd0) ? "R8" : "R3")), count, nxt);
    flip = count ^ cur;
    check("R5 bits A,B", {2'b0, flip[1:0]}, {2'b0, cur[0], 1'b1});
    check("R6 bits C,D", {2'b0, flip[3:2]},
          {2'b0, (cur[0] & cur[1] & cur[2]) | (cur[2] & cur[3]), (cur[0] & cur[1]) | (cur[2] & cur[3])});
    cur = count;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cnt_en = 1'b1;
    @(negedge clk);
    check("R1 reset value", count, 4'd1);
    rst = 1'b0;
  endtask

  task automatic t_laps();
    logic [3:0] cur;
    do_reset();
    cur = count;
    for (int i = 0; i < 36; i++) step_on(cur);
    check("R4 after three laps", count, 4'd1);
  endtask

  task automatic t_hold();
    logic [3:0] cur;
    do_reset();
    cur = count;
    for (int i = 0; i < 11; i++) step_on(cur);
    check("R2 reached 12", count, 4'd12);
    cnt_en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      #0;
      check("R9 wrap low while idle at 12", {3'b0, wrap}, 4'd0);
      @(negedge clk);
      check("R2 hold", count, 4'd12);
    end
    step_on(cur);
    check("R4 resumes to 1", count, 4'd1);
  endtask

  task automatic t_gaps();
    logic [15:0] pat = 16'hB53A;
    logic [3:0] cur;
    do_reset();
    cur = count;
    for (int lap = 0; lap < 3; lap++) begin
      for (int i = 0; i < 16; i++) begin
        if (pat[i]) begin
          step_on(cur);
        end else begin
          cnt_en = 1'b0;
          @(negedge clk);
          check("R2 gap hold", count, cur);
        end
      end
    end
  endtask

  task automatic force_code(input logic [3:0] c);
    @(negedge clk);
    rst = 1'b1;
    cnt_en = 1'b0;
    force i_hour12_counter.u_bank.state_q = c;
    @(posedge clk);
    #1;
    release i_hour12_counter.u_bank.state_q;
    rst = 1'b0;
    @(negedge clk);
    check("R7/R8 injected code", count, c);
  endtask

  task automatic t_unused();
    logic [3:0] cur;
    logic [3:0] codes [4] = '{4'd13, 4'd14, 4'd15, 4'd0};
    for (int k = 0; k < 4; k++) begin
      force_code(codes[k]);
      cur = count;
      step_on(cur);
      if (cur == 4'd0) step_on(cur);
      check("R7/R8 back in sequence", {3'b0, cur >= 4'd1 && cur <= 4'd12}, 4'd1);
      step_on(cur);
    end
  endtask

  task automatic t_reset_mid();
    logic [3:0] cur;
    do_reset();
    cur = count;
    for (int i = 0; i < 6; i++) step_on(cur);
    check("R3 mid value", count, 4'd7);
    @(negedge clk);
    rst = 1'b1;
    cnt_en = 1'b1;
    @(negedge clk);
    check("R1 reset dominates enable", count, 4'd1);
    rst = 1'b0;
    cnt_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1 initial reset", count, 4'd1);
    rst = 1'b0;
    t_laps();
    t_hold();
    t_gaps();
    t_unused();
    t_reset_mid();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

endmodule